// File: doc/BRIEF.md
# Chunked Single-Channel DMA Engine

This block is one DMA channel. It copies a run of 32-bit words from a source region to a destination region. Software sets up four configuration words through a small write port: control, size, source base and destination base. The control word must be written last, with its enable bit set, to start the run. The engine splits the run into chunks. In normal mode each chunk follows the previous one at once. In handshake mode each chunk waits until a peripheral raises a request line. Every word is one read request followed by one write request on a single memory port. Each request carries a one-bit interface select that steers it to one of two memory interfaces.

The memory port uses valid/ready. The engine raises `mem_valid` and holds the address, direction, select and write data steady until it samples `mem_ready` high on a rising edge. That edge completes the request. For a read, `mem_rdata` is taken in the same cycle that `mem_ready` is high. The memory side may keep `mem_ready` low for any number of cycles to apply back-pressure. The only case where the engine drops a request before it is accepted is a software stop, which abandons the request.

The status pins are plain levels. `busy` shows that a run is active. `done` and `err` are sticky and are cleared by the next start. `irq` is the enabled combination of `done` and `err`. The `pause` input freezes the channel at a word boundary and keeps all of its state. An optional auto-restart mode starts the run again from the same bases after each pass.

Top module: `chunk_dma`

## Requirements
- R1: The size word holds the chunk length in bits 24:16 and the total length in bits 10:0, both counted in words. For every word, the engine issues a read at the source address and then a write of exactly the data it read to the destination address.
- R2: Control bit 4 makes the source address advance by 4 after each word, and control bit 3 does the same for the destination address. When either bit is clear, that address stays at its base for the whole run.
- R3: Control bit 2 is driven on `mem_sel` during reads, and control bit 1 is driven on `mem_sel` during writes.
- R4: A chunk holds at most the chunk length in words, and the last chunk holds whatever remains. A chunk length of 0 means a single chunk of the total length.
- R5: When control bit 5 is 1 (handshake mode), no read starts at the beginning of a chunk until `hs_req` is sampled high. `hs_ack` is high for exactly that one cycle, once per chunk.
- R6: When control bit 5 is 0, chunks follow one another without any external request.
- R7: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_we`, `mem_sel` and `mem_wdata` unchanged until `mem_ready` is sampled high. A stop is the only exception.
- R8: While `pause` is 1, no new word request begins. A request that is already in flight completes. When `pause` returns to 0, the run continues from where it stopped, without losing or repeating any word.
- R9: Writing the control word with bit 9 set while busy aborts the run. On the next cycle `busy` is 0 and `err` is 1, and no further memory requests follow.
- R10: Writing the control word with bit 0 set while idle starts a run and clears `done` and `err`. `busy` is 1 until the last write completes, and then `done` is set. A total length of 0 sets `done` on the next cycle with no memory traffic.
- R11: When control bit 6 is set, completing a pass sets `done` and the run starts again from the source and destination bases with the full total length, with `busy` staying 1.
- R12: `irq` is (`done` AND control bit 18) OR (`err` AND control bit 17).
- R13: While busy, writes to any configuration word have no effect on the run, except the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word select: 0 control, 1 size, 2 source base, 3 destination base |
| cfg_wdata | input | 32 | Configuration write data |
| pause | input | 1 | Hold the channel at the next word boundary |
| hs_req | input | 1 | Chunk request in handshake mode |
| hs_ack | output | 1 | One-cycle acknowledge when a chunk is granted |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_sel | output | 1 | Interface select for the current request |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high on a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky abort flag |
| irq | output | 1 | Enabled done or error interrupt |

## Verification
The copy runs are tried against a memory whose `mem_ready` stalls at random and against one that is always ready. This shows whether requests are held steady under back-pressure and whether the order of words holds up under both. Several address patterns are used: both sides advancing, a fixed source, and a fixed destination, each with different interface selects. These show whether each increment bit and each select bit reaches only its own side. Chunk splits are checked in handshake mode by counting the reads that follow each request pulse. The cases are a total that is not a multiple of the chunk length and a chunk length of 0. Pause, stop, auto-restart, writes while busy and a total of 0 each get their own run, so that a fault in one cannot be hidden by the others.

// File: rtl/chunk_dma_pkg.sv
package chunk_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STEP,
    ST_RD,
    ST_WR
  } xfer_state_t;

  // control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_DSEL    = 1;
  localparam int CB_SSEL    = 2;
  localparam int CB_IDST    = 3;
  localparam int CB_ISRC    = 4;
  localparam int CB_HS      = 5;
  localparam int CB_AUTO    = 6;
  localparam int CB_STOP    = 9;
  localparam int CB_IE_ERR  = 17;
  localparam int CB_IE_DONE = 18;

  // size word field positions
  localparam int SZ_CHUNK_LSB = 16;
  localparam int SZ_TOTAL_LSB = 0;

  typedef struct packed {
    logic ie_done;
    logic ie_err;
    logic auto_rs;
    logic hs_mode;
    logic inc_src;
    logic inc_dst;
    logic src_sel;
    logic dst_sel;
  } chan_cfg_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import chunk_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CHUNK_W = 9,
  parameter int TOT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               busy,
  output chan_cfg_t          cfg,
  output logic [CHUNK_W-1:0] chunk_sz,
  output logic [TOT_W-1:0]   total_sz,
  output logic [AW-1:0]      src_base,
  output logic [AW-1:0]      dst_base,
  output logic               start,
  output logic               stop
);

  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_addr == 2'd0);
  assign start   = ctrl_wr && cfg_wdata[CB_EN] && !busy;
  assign stop    = ctrl_wr && cfg_wdata[CB_STOP] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      chunk_sz <= '0;
      total_sz <= '0;
      src_base <= '0;
      dst_base <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_addr)
        2'd0: begin
          cfg.ie_done <= cfg_wdata[CB_IE_DONE];
          cfg.ie_err  <= cfg_wdata[CB_IE_ERR];
          cfg.auto_rs <= cfg_wdata[CB_AUTO];
          cfg.hs_mode <= cfg_wdata[CB_HS];
          cfg.inc_src <= cfg_wdata[CB_ISRC];
          cfg.inc_dst <= cfg_wdata[CB_IDST];
          cfg.src_sel <= cfg_wdata[CB_SSEL];
          cfg.dst_sel <= cfg_wdata[CB_DSEL];
        end
        2'd1: begin
          chunk_sz <= cfg_wdata[SZ_CHUNK_LSB +: CHUNK_W];
          total_sz <= cfg_wdata[SZ_TOTAL_LSB +: TOT_W];
        end
        2'd2:    src_base <= cfg_wdata[AW-1:0];
        default: dst_base <= cfg_wdata[AW-1:0];
      endcase
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          inc_en,
  input  logic          load,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr <= '0;
    else if (load)          addr <= base;
    else if (adv && inc_en) addr <= addr + STEP_V;
  end

endmodule

// File: rtl/dma_word_count.sv
module dma_word_count #(
  parameter int CHUNK_W = 9,
  parameter int TOT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TOT_W-1:0]   total,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic               load_run,
  input  logic               load_chunk,
  input  logic               step,
  output logic               last_word,
  output logic               chunk_last
);

  logic [TOT_W-1:0] remain, chunk_cnt, chunk_eff, chunk_len;

  always_comb begin
    chunk_eff = (chunk == '0) ? total : TOT_W'(chunk);
    chunk_len = (chunk_eff < remain) ? chunk_eff : remain;
  end

  assign last_word  = (remain == TOT_W'(1));
  assign chunk_last = (chunk_cnt == TOT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      chunk_cnt <= '0;
    end else begin
      if (load_run)  remain <= total;
      else if (step) remain <= remain - TOT_W'(1);
      if (load_chunk) chunk_cnt <= chunk_len;
      else if (step)  chunk_cnt <= chunk_cnt - TOT_W'(1);
    end
  end

  // R4
  chunk_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (chunk_cnt != '0) && (chunk_cnt <= remain));

endmodule

// File: rtl/chunk_dma.sv
module chunk_dma
  import chunk_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CHUNK_W = 9,
  parameter int TOT_W   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pause,
  input  logic          hs_req,
  output logic          hs_ack,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic          mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq
);

  localparam int STEP = DW / 8;

  xfer_state_t        state;
  chan_cfg_t          cfg;
  logic [CHUNK_W-1:0] chunk_sz;
  logic [TOT_W-1:0]   total_sz;
  logic [AW-1:0]      src_base, dst_base, src_addr, dst_addr;
  logic               start, stop, go_chunk, wr_fire, restart, load_run;
  logic               last_word, chunk_last;
  logic [DW-1:0]      data_q;

  assign busy = (state != ST_IDLE);

  dma_cfg_regs #(.AW(AW), .CHUNK_W(CHUNK_W), .TOT_W(TOT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .cfg(cfg), .chunk_sz(chunk_sz),
    .total_sz(total_sz), .src_base(src_base), .dst_base(dst_base),
    .start(start), .stop(stop)
  );

  assign go_chunk = (state == ST_ARM) && !stop && !pause && (!cfg.hs_mode || hs_req);
  assign hs_ack   = go_chunk && cfg.hs_mode;
  assign wr_fire  = (state == ST_WR) && mem_ready && !stop;
  assign restart  = wr_fire && last_word && cfg.auto_rs;
  assign load_run = start || restart;

  dma_addr_gen #(.AW(AW), .STEP(STEP)) u_src (
    .clk(clk), .rst_n(rst_n), .base(src_base), .inc_en(cfg.inc_src),
    .load(load_run), .adv(wr_fire), .addr(src_addr)
  );

  dma_addr_gen #(.AW(AW), .STEP(STEP)) u_dst (
    .clk(clk), .rst_n(rst_n), .base(dst_base), .inc_en(cfg.inc_dst),
    .load(load_run), .adv(wr_fire), .addr(dst_addr)
  );

  dma_word_count #(.CHUNK_W(CHUNK_W), .TOT_W(TOT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .total(total_sz), .chunk(chunk_sz),
    .load_run(load_run), .load_chunk(go_chunk), .step(wr_fire),
    .last_word(last_word), .chunk_last(chunk_last)
  );

  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_sel   = mem_we ? cfg.dst_sel : cfg.src_sel;
  assign mem_addr  = mem_we ? dst_addr : src_addr;
  assign mem_wdata = data_q;
  assign irq       = (done && cfg.ie_done) || (err && cfg.ie_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      data_q <= '0;
    end else if (stop) begin
      state <= ST_IDLE;
      err   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          err   <= 1'b0;
          done  <= (total_sz == '0);
          state <= (total_sz == '0) ? ST_IDLE : ST_ARM;
        end
        ST_ARM:  if (go_chunk) state <= ST_RD;
        ST_STEP: if (!pause) state <= ST_RD;
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          state  <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          if (last_word) begin
            done  <= 1'b1;
            state <= cfg.auto_rs ? ST_ARM : ST_IDLE;
          end else begin
            state <= chunk_last ? ST_ARM : ST_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !stop |=> mem_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_sel) && $stable(mem_wdata));

  // R8
  pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause && ((state == ST_ARM) || (state == ST_STEP)) |=> !mem_valid);

  // R5
  hs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM) && cfg.hs_mode && !hs_req |=> !mem_valid);

  // R9
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy && err && !mem_valid);

  // R10
  zero_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (total_sz == '0) |=> done && !busy);

endmodule

// File: tb/chunk_dma_tb.sv
module chunk_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        pause = 1'b0, hs_req = 1'b0, hs_ack;
  logic        mem_valid, mem_ready = 1'b0, mem_we, mem_sel;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, err, irq;

  int total = 0, bad = 0;
  int rd_cnt = 0, hs_cnt = 0, ack_cnt = 0;
  bit fast = 1'b0, stopping = 1'b0;
  logic [65:0] expq[$];

  always #10 clk = ~clk;

  chunk_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pause(pause), .hs_req(hs_req), .hs_ack(hs_ack),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err), .irq(irq)
  );

  function automatic logic [31:0] mdata(input logic s, input logic [31:0] a);
    return a ^ (s ? 32'hA5A5_0F0F : 32'h3C3C_1234);
  endfunction

  assign mem_rdata = mdata(mem_sel, mem_addr);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder with random back-pressure
  always @(negedge clk) mem_ready <= fast ? 1'b1 : ($urandom_range(0, 3) != 0);

  // per-cycle reference comparison, sampled 1 ns before the rising edge
  initial begin
    logic pv = 1'b0, pr = 1'b0, pp = 1'b0, pw = 1'b0;
    logic [31:0] pa = 32'd0;
    forever begin
      @(negedge clk); #9;
      if (pv && !pr && !stopping)
        chk(mem_valid && mem_addr == pa && mem_we == pw, "R7 request held", {mem_valid, mem_addr}, {1'b1, pa});
      if (pp && pause && !pv)
        chk(!mem_valid, "R8 no new word while paused", mem_valid, 0);
      if (hs_ack) ack_cnt++;
      if (mem_valid && mem_ready) begin
        hs_cnt++;
        if (!mem_we) rd_cnt++;
        if (expq.size() == 0) chk(1'b0, "R9 unexpected request", mem_addr, 0);
        else begin
          logic [65:0] e, g;
          e = expq.pop_front();
          g = {mem_we, mem_sel, mem_addr, mem_we ? mem_wdata : mem_rdata};
          chk(g == e, "R1 R2 R3 request match", g, e);
        end
      end
      pv = mem_valid; pr = mem_ready; pp = pause; pw = mem_we; pa = mem_addr;
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_pass(input bit ss, input bit ds, input bit is, input bit id,
                           input int n, input logic [31:0] sb, input logic [31:0] db);
    for (int i = 0; i < n; i++) begin
      logic [31:0] sa, da;
      sa = sb + (is ? 32'(i * 4) : 32'd0);
      da = db + (id ? 32'(i * 4) : 32'd0);
      expq.push_back({1'b0, ss, sa, mdata(ss, sa)});
      expq.push_back({1'b1, ds, da, mdata(ss, sa)});
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit ss, bit ds, bit is, bit id, bit hs, bit ar, bit iee, bit ied);
    return (32'(ied) << 18) | (32'(iee) << 17) | (32'(ar) << 6) | (32'(hs) << 5)
         | (32'(is) << 4) | (32'(id) << 3) | (32'(ss) << 2) | (32'(ds) << 1) | 32'd1;
  endfunction

  task automatic start_xfer(bit ss, bit ds, bit is, bit id, bit hs, bit ar, bit iee, bit ied,
                            int chunk, int n, logic [31:0] sb, logic [31:0] db, int passes);
    for (int p = 0; p < passes; p++) push_pass(ss, ds, is, id, n, sb, db);
    cfg_write(2'd1, (32'(chunk) << 16) | 32'(n));
    cfg_write(2'd2, sb);
    cfg_write(2'd3, db);
    cfg_write(2'd0, mk_ctrl(ss, ds, is, id, hs, ar, iee, ied));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic hs_pulse();
    @(negedge clk); hs_req = 1'b1;
    @(negedge clk); hs_req = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk({busy, done, err, irq, mem_valid} == 5'b0, "R10 reset state", {busy, done, err, irq, mem_valid}, 0);

    // R1 R2 R3 R4 R6 R12: both advancing, remainder chunk, random stalls
    start_xfer(0, 1, 1, 1, 0, 0, 0, 1, 3, 7, 32'h0000_1000, 32'h0000_8000, 1);
    wait_idle();
    chk(expq.size() == 0, "R1 all words moved", expq.size(), 0);
    chk(done && !busy && !err, "R10 done after run", {busy, done, err}, 3'b010);
    chk(irq, "R12 done interrupt enabled", irq, 1);

    // R2 fixed source, chunk 0, interrupt off
    start_xfer(1, 0, 0, 1, 0, 0, 0, 0, 0, 5, 32'h0000_2000, 32'h0000_9000, 1);
    wait_idle();
    chk(expq.size() == 0, "R2 fixed source run", expq.size(), 0);
    chk(done && !irq, "R12 done interrupt masked", {done, irq}, 2'b10);

    // R2 fixed destination
    start_xfer(1, 1, 1, 0, 0, 0, 0, 0, 2, 4, 32'h0000_3000, 32'h0000_A000, 1);
    wait_idle();
    chk(expq.size() == 0, "R2 fixed destination run", expq.size(), 0);

    // R10 zero total
    start_xfer(0, 0, 1, 1, 0, 0, 0, 1, 2, 0, 32'h0000_4000, 32'h0000_B000, 1);
    @(negedge clk);
    chk(done && !busy && irq, "R10 zero total completes", {busy, done, irq}, 3'b011);

    // R4 R5 handshake chunking 2,2,1
    fast = 1'b1;
    ack_cnt = 0;
    start_xfer(0, 1, 1, 1, 1, 0, 0, 1, 2, 5, 32'h0000_5000, 32'h0000_C000, 1);
    base_rd = rd_cnt;
    repeat (15) @(negedge clk);
    chk(rd_cnt == base_rd, "R5 waits for request", rd_cnt - base_rd, 0);
    hs_pulse();
    chk(rd_cnt - base_rd == 2, "R4 first chunk", rd_cnt - base_rd, 2);
    hs_pulse();
    chk(rd_cnt - base_rd == 4, "R4 second chunk", rd_cnt - base_rd, 4);
    hs_pulse();
    chk(rd_cnt - base_rd == 5, "R4 remainder chunk", rd_cnt - base_rd, 5);
    chk(done && !busy, "R5 run done", {busy, done}, 2'b01);
    chk(ack_cnt == 3, "R5 one ack per chunk", ack_cnt, 3);

    // R4 chunk 0 in handshake mode is one chunk
    start_xfer(1, 0, 1, 1, 1, 0, 0, 0, 0, 4, 32'h0000_5100, 32'h0000_C100, 1);
    base_rd = rd_cnt;
    hs_pulse();
    chk(rd_cnt - base_rd == 4 && !busy, "R4 zero chunk means total", rd_cnt - base_rd, 4);

    // R8 pause
    start_xfer(0, 0, 1, 1, 0, 0, 0, 1, 4, 20, 32'h0000_6000, 32'h0000_D000, 1);
    repeat (6) @(negedge clk);
    pause = 1'b1;
    repeat (10) @(negedge clk);
    base_rd = hs_cnt;
    repeat (20) @(negedge clk);
    chk(hs_cnt == base_rd && busy, "R8 frozen while paused", hs_cnt - base_rd, 0);
    pause = 1'b0;
    wait_idle();
    chk(expq.size() == 0 && done, "R8 resumes without loss", expq.size(), 0);
    fast = 1'b0;

    // R13 writes during busy ignored
    start_xfer(0, 1, 1, 1, 0, 0, 0, 1, 2, 6, 32'h0000_7000, 32'h0000_E000, 1);
    cfg_write(2'd2, 32'h0000_F000);
    cfg_write(2'd1, 32'd3);
    cfg_write(2'd0, mk_ctrl(1, 0, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk(expq.size() == 0, "R13 run unaffected", expq.size(), 0);
    chk(irq, "R13 interrupt enable kept", irq, 1);

    // R9 stop
    start_xfer(0, 1, 1, 1, 0, 0, 1, 0, 8, 60, 32'h0001_0000, 32'h0002_0000, 1);
    repeat (20) @(negedge clk);
    stopping = 1'b1;
    cfg_write(2'd0, 32'h0000_0200);
    expq.delete();
    @(negedge clk);
    chk(!busy && err && irq, "R9 stop aborts", {busy, err, irq}, 3'b011);
    repeat (30) @(negedge clk);
    stopping = 1'b0;
    chk(!mem_valid, "R9 bus quiet after stop", mem_valid, 0);

    // R11 auto restart
    start_xfer(1, 1, 1, 1, 0, 1, 0, 1, 2, 3, 32'h0003_0000, 32'h0004_0000, 4);
    chk(!done && !err, "R10 flags cleared on start", {done, err}, 0);
    for (int i = 0; i < 2000 && expq.size() > 18; i++) @(negedge clk);
    @(negedge clk);
    chk(done && busy, "R11 done while restarting", {busy, done}, 2'b11);
    for (int i = 0; i < 3000 && expq.size() > 6; i++) @(negedge clk);
    stopping = 1'b1;
    cfg_write(2'd0, 32'h0000_0200);
    expq.delete();
    @(negedge clk);
    stopping = 1'b0;
    chk(!busy && err, "R11 restarted passes matched", {busy, err}, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule